// File: doc/BRIEF.md
# Flash Block Lock-Bit Command Controller

This block is the command front end that guards the per-block protection bits of a parallel NOR-style flash model. A host issues byte-wide commands, each with an address, on a write port. Protection bits are only altered by a two-write sequence. The first write is a setup byte. The second write confirms either setting the bit of one block or clearing the bits of all blocks together. After the confirm, a timed internal operation runs. A ready output and bit 7 of the status byte report when it has finished.

Error conditions are recorded in sticky status bits, and a clear-status command resets them. A sequence that is not valid, a request made while a suspend flag is raised, and a request made while the protect-voltage input is not valid are all refused. None of them changes any protection bit. The current protection bits are exported. They also drive a combinational gate that refuses program and erase requests aimed at a protected block.

Top module: `lockctl_top`

## Requirements
- R1: Writing 0x60 and then 0x01, both to addresses in the same block, starts a set operation. `ready` is low for exactly SET_CYC cycles after the confirm edge. At the edge where `ready` returns high, that block's bit in `lock_bits` becomes 1 and the other bits keep their values.
- R2: Writing 0x60 and then 0xD0 starts a clear-all operation. `ready` is low for exactly CLR_CYC cycles. At the edge where `ready` returns high, every bit of `lock_bits` becomes 0.
- R3: Any write accepted while `ready` is low is ignored: it changes no state, status or protection bit. If `suspend_i` is high at a valid confirm, the operation is refused. A refused set sets status bit 4 and a refused clear sets status bit 5. `ready` stays high.
- R4: After a 0x60 write, `stat_mode` is 1 and `rd_data` returns the status byte. The mode persists through 0x60 and 0x50 writes and through the confirm. Any other byte written with no sequence pending sets `stat_mode` to 0, and `rd_data` then reads 0x00.
- R5: Status bit 7 equals `ready`. Status bits 6, 2, 1 and 0 always read 0.
- R6: A second byte other than 0x01 or 0xD0 after 0x60, or an 0x01 confirm addressed to a different block than its setup, sets status bits 4 and 5 together. It changes no protection bit.
- R7: If `wp_ok` is low at a valid confirm, no protection bit changes. Status bit 3 is set together with bit 4 (set) or bit 5 (clear).
- R8: Status bits 3, 4 and 5 stay set until a 0x50 write with no sequence pending, which clears all three.
- R9: `req_ok` equals `req_valid` AND NOT the protection bit of the block addressed by `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | BLK_W+OFS_W | Write address; the upper BLK_W bits select the block |
| wr_data | input | 8 | Command byte |
| wp_ok | input | 1 | Protect voltage valid; 0 forbids protection changes |
| suspend_i | input | 1 | Device suspended flag |
| rd_data | output | 8 | Status byte in status mode, else 0x00 |
| stat_mode | output | 1 | Reads currently return status |
| ready | output | 1 | High when no internal operation runs |
| lock_bits | output | NBLK | Protection bit per block |
| req_valid | input | 1 | Program/erase request present |
| req_addr | input | BLK_W+OFS_W | Address of the program/erase request |
| req_ok | output | 1 | Request allowed |

## Verification
The situation that is hardest to reach from the ports is a command byte that arrives during the busy window. Such a byte could be mistaken for the confirm of a pending sequence. The bench writes a full setup/confirm pair while a clear-all is running. Once ready returns, it writes a lone 0x01 and checks two things: protection bits stay unchanged, and status mode is dropped instead of a confirm being taken. The bench also walks all sixteen protection patterns of a four-block setup and checks the request gate for every block in each pattern.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;
    localparam logic [7:0] OP_SETUP = 8'h60;
    localparam logic [7:0] OP_SET   = 8'h01;
    localparam logic [7:0] OP_CLRALL = 8'hD0;
    localparam logic [7:0] OP_CLRST = 8'h50;

    typedef enum logic {SQ_IDLE, SQ_ARMED} seq_st_e;
endpackage

// File: rtl/lockctl_timer.sv
module lockctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = r_q.busy && (r_q.cnt == '0);
        if (load) begin
            r_d.busy = 1'b1;
            r_d.cnt  = load_val;
        end else if (done) begin
            r_d.busy = 1'b0;
        end else if (r_q.busy) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy = r_q.busy;
endmodule

// File: rtl/lockctl_bits.sv
module lockctl_bits #(
    parameter int NBLK  = 8,
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_idx,
    input  logic             clr_all,
    output logic [NBLK-1:0]  bits
);
    logic [NBLK-1:0] bits_d, bits_q;

    for (genvar g = 0; g < NBLK; g++) begin : g_bit
        always_comb begin
            bits_d[g] = bits_q[g];
            if (clr_all)                                   bits_d[g] = 1'b0;
            else if (set_en && (set_idx == BLK_W'(g)))     bits_d[g] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits = bits_q;
endmodule

// File: rtl/lockctl_seq.sv
module lockctl_seq
    import lockctl_pkg::*;
#(
    parameter int BLK_W   = 3,
    parameter int CNT_W   = 4,
    parameter int SET_CYC = 5,
    parameter int CLR_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [7:0]       wr_data,
    input  logic             wp_ok,
    input  logic             suspend_i,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output logic [CNT_W-1:0] start_cnt,
    output logic             set_en,
    output logic             clr_all,
    output logic [BLK_W-1:0] op_blk,
    output logic             stat_mode,
    output logic [7:0]       status
);
    typedef struct packed {
        seq_st_e          st;
        logic [BLK_W-1:0] blk;
        logic             op_clr;
        logic             smode;
        logic             e_clr;
        logic             e_set;
        logic             e_wp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        logic good, is_clr;
        s_d       = s_q;
        start     = 1'b0;
        start_cnt = '0;
        good      = 1'b0;
        is_clr    = 1'b0;
        if (wr_en && !busy) begin
            if (s_q.st == SQ_IDLE) begin
                if (wr_data == OP_SETUP) begin
                    s_d.st    = SQ_ARMED;
                    s_d.blk   = wr_blk;
                    s_d.smode = 1'b1;
                end else if (wr_data == OP_CLRST) begin
                    s_d.e_clr = 1'b0;
                    s_d.e_set = 1'b0;
                    s_d.e_wp  = 1'b0;
                end else begin
                    s_d.smode = 1'b0;
                end
            end else begin
                s_d.st = SQ_IDLE;
                if (wr_data == OP_SET && wr_blk == s_q.blk) begin
                    good = 1'b1;
                end else if (wr_data == OP_CLRALL) begin
                    good   = 1'b1;
                    is_clr = 1'b1;
                end else begin
                    s_d.e_clr = 1'b1;
                    s_d.e_set = 1'b1;
                end
                if (good) begin
                    if (suspend_i || !wp_ok) begin
                        if (is_clr) s_d.e_clr = 1'b1;
                        else        s_d.e_set = 1'b1;
                        if (!suspend_i) s_d.e_wp = 1'b1;
                    end else begin
                        start      = 1'b1;
                        s_d.op_clr = is_clr;
                        start_cnt  = is_clr ? CNT_W'(CLR_CYC - 1) : CNT_W'(SET_CYC - 1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign set_en    = done && !s_q.op_clr;
    assign clr_all   = done && s_q.op_clr;
    assign op_blk    = s_q.blk;
    assign stat_mode = s_q.smode;
    assign status    = {!busy, 1'b0, s_q.e_clr, s_q.e_set, s_q.e_wp, 3'b000};
endmodule

// File: rtl/lockctl_top.sv
module lockctl_top #(
    parameter int NBLK    = 8,
    parameter int OFS_W   = 4,
    parameter int SET_CYC = 5,
    parameter int CLR_CYC = 12,
    localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int AW     = BLK_W + OFS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            wp_ok,
    input  logic            suspend_i,
    output logic [7:0]      rd_data,
    output logic            stat_mode,
    output logic            ready,
    output logic [NBLK-1:0] lock_bits,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            req_ok
);
    localparam int MAXC  = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             start, busy, done, set_en, clr_all;
    logic [CNT_W-1:0] start_cnt;
    logic [BLK_W-1:0] op_blk;
    logic [7:0]       status;

    lockctl_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W), .SET_CYC(SET_CYC), .CLR_CYC(CLR_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_addr[AW-1:OFS_W]),
        .wr_data(wr_data), .wp_ok(wp_ok), .suspend_i(suspend_i), .busy(busy),
        .done(done), .start(start), .start_cnt(start_cnt), .set_en(set_en),
        .clr_all(clr_all), .op_blk(op_blk), .stat_mode(stat_mode), .status(status)
    );

    lockctl_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(start), .load_val(start_cnt),
        .busy(busy), .done(done)
    );

    lockctl_bits #(.NBLK(NBLK), .BLK_W(BLK_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(op_blk),
        .clr_all(clr_all), .bits(lock_bits)
    );

    assign ready   = !busy;
    assign rd_data = stat_mode ? status : 8'h00;
    assign req_ok  = req_valid && !lock_bits[req_addr[AW-1:OFS_W]];
endmodule

// File: rtl/lockctl_chk.sv
module lockctl_chk #(
    parameter int NBLK  = 8,
    parameter int OFS_W = 4,
    parameter int AW    = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      rd_data,
    input logic            stat_mode,
    input logic            ready,
    input logic [NBLK-1:0] lock_bits,
    input logic            req_valid,
    input logic [AW-1:0]   req_addr,
    input logic            req_ok
);
    AST_LOCK_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bits != $past(lock_bits)) |-> (!$past(ready) && ready)); // R1
    AST_CHANGE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bits != $past(lock_bits)) |-> ((lock_bits == '0) ||
            (($countones(lock_bits ^ $past(lock_bits)) == 1) &&
             ((lock_bits & $past(lock_bits)) == $past(lock_bits))))); // R2
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en && stat_mode) |=> $stable(rd_data[5:3])); // R3
    AST_MODE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_mode |-> (rd_data == 8'h00)); // R4
    AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode |-> ((rd_data[7] == ready) && (rd_data[6] == 1'b0) && (rd_data[2:0] == 3'b000))); // R5
    AST_WP_WITH_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode && rd_data[3]) |-> (rd_data[4] || rd_data[5])); // R7
    AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_bits[req_addr[AW-1:OFS_W]]) |-> !req_ok); // R9
endmodule

bind lockctl_top lockctl_chk #(.NBLK(NBLK), .OFS_W(OFS_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data), .stat_mode(stat_mode),
    .ready(ready), .lock_bits(lock_bits), .req_valid(req_valid), .req_addr(req_addr),
    .req_ok(req_ok)
);

// File: tb/tb_lockctl_top.sv
`timescale 1ns/1ps
module tb_lockctl_top;
    localparam int NB = 4, OW = 2, SC = 3, CC = 6, AW = 4;

    logic clk = 0, rst_n = 0, wr_en = 0, wp_ok = 1, suspend_i = 0, req_valid = 0;
    logic [AW-1:0] wr_addr = '0, req_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic stat_mode, ready, req_ok;
    logic [NB-1:0] lock_bits;
    int checks = 0, fails = 0;
    logic [NB-1:0] exp_lk = '0;

    always #10 clk = ~clk;

    lockctl_top #(.NBLK(NB), .OFS_W(OW), .SET_CYC(SC), .CLR_CYC(CC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp_ok(wp_ok), .suspend_i(suspend_i), .rd_data(rd_data), .stat_mode(stat_mode),
        .ready(ready), .lock_bits(lock_bits), .req_valid(req_valid), .req_addr(req_addr),
        .req_ok(req_ok));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int blk, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'((blk << OW) | (blk & 3)); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic gate_sweep(input logic [NB-1:0] lk);
        for (int q = 0; q < NB; q++) begin
            req_valid = 1; req_addr = AW'((q << OW) | 1);
            #1 chk("R9 gate", req_ok, !lk[q]);
            req_valid = 0;
            #1 chk("R9 idle", req_ok, 0);
        end
    endtask

    task automatic run_op(input string req, input int blk, input logic [7:0] conf, input int n);
        wr(blk, 8'h60);
        wr(blk, conf);
        chk({req, " busy"}, ready, 0);
        chk("R5 bit7", rd_data[7], 0);
        repeat (n - 1) @(negedge clk);
        chk({req, " still busy"}, ready, 0);
        @(negedge clk);
        chk({req, " ready"}, ready, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                chk("R5 reset ready", ready, 1);
                chk("R1 reset locks", lock_bits, 0);
                chk("R4 reset mode", stat_mode, 0);
                chk("R4 reset rd", rd_data, 0);

                for (int m = 0; m < 16; m++) begin
                    run_op("R2", 0, 8'hD0, CC);
                    exp_lk = '0;
                    chk("R2 cleared", lock_bits, 0);
                    for (int b = 0; b < NB; b++) if (m[b]) begin
                        run_op("R1", b, 8'h01, SC);
                        exp_lk[b] = 1'b1;
                        chk("R1 lock", lock_bits, exp_lk);
                    end
                    chk("R4 mode", stat_mode, 1);
                    chk("R5 status", rd_data, 8'h80);
                    gate_sweep(exp_lk);
                end

                // R6 bad second byte and block mismatch
                wr(1, 8'h60); wr(1, 8'hFF);
                chk("R6 bad byte", rd_data, 8'hB0);
                chk("R6 locks", lock_bits, exp_lk);
                wr(1, 8'h50);
                chk("R8 clear", rd_data, 8'h80);
                wr(0, 8'h60); wr(2, 8'h01);
                chk("R6 mismatch", rd_data, 8'hB0);
                chk("R6 locks2", lock_bits, exp_lk);
                wr(0, 8'h60);
                chk("R8 sticky", rd_data, 8'hB0);
                wr(0, 8'h50);
                chk("R8 in armed", rd_data, 8'hB0);
                wr(0, 8'h50);
                chk("R8 cleared", rd_data, 8'h80);
                wr(0, 8'hFF);
                chk("R4 mode off", stat_mode, 0);
                chk("R4 rd zero", rd_data, 8'h00);

                // R7 protect voltage
                run_op("R2", 0, 8'hD0, CC);
                exp_lk = '0;
                wp_ok = 0;
                wr(2, 8'h60); wr(2, 8'h01);
                chk("R7 ready", ready, 1);
                chk("R7 set status", rd_data, 8'h98);
                wr(2, 8'h50);
                wr(0, 8'h60); wr(0, 8'hD0);
                chk("R7 clr status", rd_data, 8'hA8);
                wp_ok = 1;
                @(negedge clk);
                chk("R7 locks", lock_bits, 0);
                wr(0, 8'h50);

                // R3 suspend
                suspend_i = 1;
                wr(3, 8'h60); wr(3, 8'h01);
                chk("R3 susp set", rd_data, 8'h90);
                chk("R3 susp ready", ready, 1);
                wr(0, 8'h50);
                wr(0, 8'h60); wr(0, 8'hD0);
                chk("R3 susp clr", rd_data, 8'hA0);
                suspend_i = 0;
                wr(0, 8'h50);
                chk("R3 locks", lock_bits, 0);

                // R3 writes during busy ignored
                run_op("R1", 1, 8'h01, SC);
                wr(3, 8'h60); wr(3, 8'hD0);
                chk("R2 start", ready, 0);
                wr(2, 8'h60); wr(2, 8'h01); wr(2, 8'hFF);
                chk("R3 no err", rd_data[5:3], 3'b000);
                repeat (CC) @(negedge clk);
                chk("R2 done", ready, 1);
                chk("R2 all clr", lock_bits, 0);
                wr(2, 8'h01);
                chk("R3 not armed", stat_mode, 0);
                chk("R3 no set", lock_bits, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule